// File: doc/BRIEF.md
# SDRAM Mode Register Capture Unit

This block sits on the device side of a double-data-rate SDRAM command interface. It watches the command strobes on every rising clock edge and picks out the single opcode that loads configuration. Bank address bit 0 chooses the target. Bank address 0 loads the primary mode register, which holds burst length, burst ordering, read latency, the test-mode flag and the DLL-reset request. Bank address 1 loads the extended register, which holds the DLL enable and the output drive-strength code.

The block takes a write only when all of these hold: every bank is idle, the encoding is legal, and the minimum gap since the last accepted load has elapsed. Any other load attempt is refused, the stored settings are left as they were, and an error flag is raised. Each register has a valid bit, so downstream logic can tell an unprogrammed register from a programmed one. A busy output marks the recovery window after each accepted load.

Top module: `sdram_mode_capture`

## Requirements
- R1: A load attempt is a rising edge at which cs_n, ras_n, cas_n and we_n are all 0, with cke high at this edge and at the edge before it. With cs_n high, or with cke low at the previous edge, the opcode changes neither the settings nor cfg_err.
- R2: ba[0]=0 targets the primary register and ba[0]=1 targets the extended register. A load into one register leaves the other register's outputs unchanged.
- R3: In the primary register, addr[2:0] sets the burst. Code 001 gives burst_beats=2, 010 gives 4 and 011 gives 8. addr[3] sets burst_interleave (0 sequential, 1 interleaved).
- R4: In the primary register, addr[6:4] must be 011, and cas_latency then reads 3. addr[7] drives test_mode and addr[8] drives dll_reset.
- R5: In the extended register, addr[0]=0 gives dll_enable=1 and addr[0]=1 gives dll_enable=0. drive_code is {addr[6], addr[1]}.
- R6: The following attempts are refused with cfg_err=1 in the cycle after the edge, and the register is left unchanged: a burst code other than 001/010/011, a latency code other than 011, ba[1]=1, any of addr[11:9] set in a primary load, or any of addr[5:2] or addr[11:7] set in an extended load.
- R7: An attempt made while banks_idle is 0 is refused with cfg_err=1, and the register is left unchanged.
- R8: After an accepted load, busy is 1 for TMRD-1 cycles (1 cycle at the default of 2). An attempt at an edge where busy is 1 is refused with cfg_err=1, and the register is left unchanged.
- R9: Reset clears all outputs to 0, including mr_valid, emr_valid, cfg_err and busy.
- R10: mr_valid and emr_valid each go to 1 on the first accepted load of their register and stay at 1 until reset.
- R11: cfg_err is updated only by load attempts. An accepted load clears it, and other commands leave it as it is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| cke | input | 1 | Clock enable |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write strobe, active low |
| ba | input | 2 | Bank address; bit 0 picks the register |
| addr | input | ADDR_W | Address pins carrying the register value |
| banks_idle | input | 1 | 1 when every bank is precharged |
| burst_beats | output | 4 | Burst length in beats (2, 4 or 8) |
| burst_interleave | output | 1 | 1 = interleaved burst order |
| cas_latency | output | 3 | Read latency in clocks |
| test_mode | output | 1 | Test-mode bit as loaded |
| dll_reset | output | 1 | DLL reset request as loaded |
| dll_enable | output | 1 | 1 = DLL enabled |
| drive_code | output | 2 | Output drive-strength code |
| mr_valid | output | 1 | Primary register programmed |
| emr_valid | output | 1 | Extended register programmed |
| cfg_err | output | 1 | Last load attempt was refused |
| busy | output | 1 | Recovery window after an accepted load |

## Verification
The bench fires a load on the edge right after an accepted one. A design that counts the recovery window one cycle short would take that second load, and the burst length would change when it should not. It also sends a legal encoding while a bank is open, and the same opcode with chip select high or with clock enable just restored. A design that checks only the encoding would update its settings in these cases. Reserved burst and latency codes and stray reserved bits in each register are tried one at a time. This exposes a decoder that silently maps them to a length, or that clears the valid bit and the retained settings on a refusal.

// File: rtl/mrc_pkg.sv
package mrc_pkg;

   typedef struct packed {
      logic [3:0] beats;
      logic       interleave;
      logic [2:0] cas_lat;
      logic       test_mode;
      logic       dll_rst;
   } mr_fields_t;

   typedef struct packed {
      logic       dll_en;
      logic [1:0] drive;
   } emr_fields_t;

   // burst code to beat count; 0 marks a reserved code
   function automatic logic [3:0] burst_code_to_beats(input logic [2:0] code);
      logic [3:0] beats;
      case (code)
         3'b001:  beats = 4'd2;
         3'b010:  beats = 4'd4;
         3'b011:  beats = 4'd8;
         default: beats = 4'd0;
      endcase
      return beats;
   endfunction

endpackage

// File: rtl/mrc_cmd_decode.sv
module mrc_cmd_decode (
   input  logic clk,
   input  logic rst_n,
   input  logic cke,
   input  logic cs_n,
   input  logic ras_n,
   input  logic cas_n,
   input  logic we_n,
   output logic load_attempt
);

   logic cke_prev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cke_prev <= 1'b0;
      else        cke_prev <= cke;
   end

   always_comb begin
      load_attempt = cke & cke_prev & ~cs_n & ~ras_n & ~cas_n & ~we_n;
   end

endmodule

// File: rtl/mrc_guard_timer.sv
module mrc_guard_timer #(
   parameter int unsigned TMRD = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic busy
);

   localparam int unsigned CW = (TMRD > 2) ? $clog2(TMRD) : 1;
   localparam logic [CW-1:0] RELOAD = CW'(TMRD - 1);

   logic [CW-1:0] remain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               remain <= '0;
      else if (start)           remain <= RELOAD;
      else if (remain != '0)    remain <= remain - 1'b1;
   end

   always_comb begin
      busy = (remain != '0);
   end

endmodule

// File: rtl/mrc_field_check.sv
module mrc_field_check
   import mrc_pkg::*;
#(
   parameter int unsigned ADDR_W  = 12,
   parameter logic [2:0]  CL_CODE = 3'b011
) (
   input  logic [1:0]        ba,
   input  logic [ADDR_W-1:0] addr,
   output mr_fields_t        mr_next,
   output emr_fields_t       emr_next,
   output logic              sel_ext,
   output logic              fields_ok
);

   localparam int unsigned MR_RFU_LO = 9;

   logic [ADDR_W-1:0] mr_rfu_hit;
   logic [ADDR_W-1:0] emr_rfu_hit;
   logic              burst_ok;
   logic              lat_ok;
   logic              mr_ok;
   logic              emr_ok;

   // per-bit reserved masks built from the address width
   for (genvar i = 0; i < ADDR_W; i++) begin : g_rfu
      if (i >= MR_RFU_LO) begin : g_mr_res
         assign mr_rfu_hit[i] = addr[i];
      end else begin : g_mr_use
         assign mr_rfu_hit[i] = 1'b0;
      end
      if (i == 0 || i == 1 || i == 6) begin : g_emr_use
         assign emr_rfu_hit[i] = 1'b0;
      end else begin : g_emr_res
         assign emr_rfu_hit[i] = addr[i];
      end
   end

   always_comb begin
      mr_next.beats      = burst_code_to_beats(addr[2:0]);
      mr_next.interleave = addr[3];
      mr_next.cas_lat    = addr[6:4];
      mr_next.test_mode  = addr[7];
      mr_next.dll_rst    = addr[8];

      emr_next.dll_en    = ~addr[0];
      emr_next.drive     = {addr[6], addr[1]};

      burst_ok  = (mr_next.beats != 4'd0);
      lat_ok    = (addr[6:4] == CL_CODE);
      mr_ok     = burst_ok & lat_ok & ~ba[1] & ~(|mr_rfu_hit);
      emr_ok    = ~ba[1] & ~(|emr_rfu_hit);
      sel_ext   = ba[0];
      fields_ok = sel_ext ? emr_ok : mr_ok;
   end

endmodule

// File: rtl/sdram_mode_capture.sv
module sdram_mode_capture
   import mrc_pkg::*;
#(
   parameter int unsigned ADDR_W  = 12,
   parameter int unsigned TMRD    = 2,
   parameter logic [2:0]  CL_CODE = 3'b011
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cke,
   input  logic              cs_n,
   input  logic              ras_n,
   input  logic              cas_n,
   input  logic              we_n,
   input  logic [1:0]        ba,
   input  logic [ADDR_W-1:0] addr,
   input  logic              banks_idle,
   output logic [3:0]        burst_beats,
   output logic              burst_interleave,
   output logic [2:0]        cas_latency,
   output logic              test_mode,
   output logic              dll_reset,
   output logic              dll_enable,
   output logic [1:0]        drive_code,
   output logic              mr_valid,
   output logic              emr_valid,
   output logic              cfg_err,
   output logic              busy
);

   if (ADDR_W < 9) begin : g_bad_width
      $error("sdram_mode_capture: ADDR_W must cover bit 8");
   end
   if (TMRD < 2) begin : g_bad_tmrd
      $error("sdram_mode_capture: TMRD must be at least 2");
   end

   logic        load_attempt;
   logic        sel_ext;
   logic        fields_ok;
   logic        accept;
   mr_fields_t  mr_next;
   emr_fields_t emr_next;
   mr_fields_t  mr_q;
   emr_fields_t emr_q;
   logic        mr_v_q;
   logic        emr_v_q;
   logic        err_q;

   mrc_cmd_decode u_dec (
      .clk          (clk),
      .rst_n        (rst_n),
      .cke          (cke),
      .cs_n         (cs_n),
      .ras_n        (ras_n),
      .cas_n        (cas_n),
      .we_n         (we_n),
      .load_attempt (load_attempt)
   );

   mrc_field_check #(
      .ADDR_W  (ADDR_W),
      .CL_CODE (CL_CODE)
   ) u_chkf (
      .ba        (ba),
      .addr      (addr),
      .mr_next   (mr_next),
      .emr_next  (emr_next),
      .sel_ext   (sel_ext),
      .fields_ok (fields_ok)
   );

   mrc_guard_timer #(
      .TMRD (TMRD)
   ) u_tmr (
      .clk   (clk),
      .rst_n (rst_n),
      .start (accept),
      .busy  (busy)
   );

   always_comb begin
      accept = load_attempt & ~busy & banks_idle & fields_ok;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mr_q    <= '0;
         emr_q   <= '0;
         mr_v_q  <= 1'b0;
         emr_v_q <= 1'b0;
         err_q   <= 1'b0;
      end else begin
         if (load_attempt) err_q <= ~accept;
         if (accept) begin
            if (sel_ext) begin
               emr_q   <= emr_next;
               emr_v_q <= 1'b1;
            end else begin
               mr_q    <= mr_next;
               mr_v_q  <= 1'b1;
            end
         end
      end
   end

   always_comb begin
      burst_beats      = mr_q.beats;
      burst_interleave = mr_q.interleave;
      cas_latency      = mr_q.cas_lat;
      test_mode        = mr_q.test_mode;
      dll_reset        = mr_q.dll_rst;
      dll_enable       = emr_q.dll_en;
      drive_code       = emr_q.drive;
      mr_valid         = mr_v_q;
      emr_valid        = emr_v_q;
      cfg_err          = err_q;
   end

endmodule

// File: rtl/mrc_checker.sv
module mrc_checker #(
   parameter int unsigned ADDR_W  = 12,
   parameter logic [2:0]  CL_CODE = 3'b011
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cke,
   input logic              cs_n,
   input logic              ras_n,
   input logic              cas_n,
   input logic              we_n,
   input logic [1:0]        ba,
   input logic [ADDR_W-1:0] addr,
   input logic              banks_idle,
   input logic [3:0]        burst_beats,
   input logic              burst_interleave,
   input logic [2:0]        cas_latency,
   input logic              test_mode,
   input logic              dll_reset,
   input logic              dll_enable,
   input logic [1:0]        drive_code,
   input logic              mr_valid,
   input logic              emr_valid,
   input logic              cfg_err,
   input logic              busy
);

   logic        cke_seen;
   logic        opcode;
   logic [15:0] cfg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cke_seen <= 1'b0;
      else        cke_seen <= cke;
   end

   always_comb begin
      opcode = cke & cke_seen & ~cs_n & ~ras_n & ~cas_n & ~we_n;
      cfg    = {burst_beats, burst_interleave, cas_latency, test_mode,
                dll_reset, dll_enable, drive_code, mr_valid, emr_valid};
   end

   p_deselect_ignored_r1: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n |=> $stable({cfg, cfg_err}));

   p_cke_low_ignored_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !cke |=> $stable({cfg, cfg_err}));

   p_beats_legal_r3: assert property (@(posedge clk) disable iff (!rst_n)
      mr_valid |-> (burst_beats == 4'd2 || burst_beats == 4'd4 || burst_beats == 4'd8));

   p_latency_legal_r4: assert property (@(posedge clk) disable iff (!rst_n)
      mr_valid |-> (cas_latency == CL_CODE));

   p_ba1_refused_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (opcode && ba[1]) |=> (cfg_err && $stable(cfg)));

   p_open_bank_refused_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (opcode && !banks_idle) |=> (cfg_err && $stable(cfg)));

   p_busy_freezes_r8: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> $stable(cfg));

   p_busy_after_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(mr_valid) || $rose(emr_valid)) |-> busy);

   p_valid_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (mr_valid || emr_valid) |=> ($past(mr_valid) -> mr_valid) && ($past(emr_valid) -> emr_valid));

endmodule

bind sdram_mode_capture mrc_checker #(
   .ADDR_W  (ADDR_W),
   .CL_CODE (CL_CODE)
) u_chk (
   .clk              (clk),
   .rst_n            (rst_n),
   .cke              (cke),
   .cs_n             (cs_n),
   .ras_n            (ras_n),
   .cas_n            (cas_n),
   .we_n             (we_n),
   .ba               (ba),
   .addr             (addr),
   .banks_idle       (banks_idle),
   .burst_beats      (burst_beats),
   .burst_interleave (burst_interleave),
   .cas_latency      (cas_latency),
   .test_mode        (test_mode),
   .dll_reset        (dll_reset),
   .dll_enable       (dll_enable),
   .drive_code       (drive_code),
   .mr_valid         (mr_valid),
   .emr_valid        (emr_valid),
   .cfg_err          (cfg_err),
   .busy             (busy)
);

// File: tb/sdram_mode_capture_tb.sv
module sdram_mode_capture_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cke = 1'b0;
   logic        cs_n = 1'b1;
   logic        ras_n = 1'b1;
   logic        cas_n = 1'b1;
   logic        we_n = 1'b1;
   logic [1:0]  ba = '0;
   logic [11:0] addr = '0;
   logic        banks_idle = 1'b1;
   logic [3:0]  burst_beats;
   logic        burst_interleave;
   logic [2:0]  cas_latency;
   logic        test_mode;
   logic        dll_reset;
   logic        dll_enable;
   logic [1:0]  drive_code;
   logic        mr_valid;
   logic        emr_valid;
   logic        cfg_err;
   logic        busy;

   int n_chk = 0;
   int n_bad = 0;

   always #10 clk = ~clk;

   sdram_mode_capture u_dut (
      .clk (clk), .rst_n (rst_n), .cke (cke), .cs_n (cs_n),
      .ras_n (ras_n), .cas_n (cas_n), .we_n (we_n), .ba (ba),
      .addr (addr), .banks_idle (banks_idle),
      .burst_beats (burst_beats), .burst_interleave (burst_interleave),
      .cas_latency (cas_latency), .test_mode (test_mode),
      .dll_reset (dll_reset), .dll_enable (dll_enable),
      .drive_code (drive_code), .mr_valid (mr_valid),
      .emr_valid (emr_valid), .cfg_err (cfg_err), .busy (busy)
   );

   // {ba, addr, idle | err, beats, ilv, tm, dllrst, dllen, drive, mv, ev, cl}
   localparam logic [30:0] VEC [15] = '{
      {2'b00, 12'h032, 1'b1, 1'b0, 4'd4, 1'b0, 1'b0, 1'b0, 1'b0, 2'b00, 1'b1, 1'b0, 3'd3},
      {2'b00, 12'h13B, 1'b1, 1'b0, 4'd8, 1'b1, 1'b0, 1'b1, 1'b0, 2'b00, 1'b1, 1'b0, 3'd3},
      {2'b00, 12'h034, 1'b1, 1'b1, 4'd8, 1'b1, 1'b0, 1'b1, 1'b0, 2'b00, 1'b1, 1'b0, 3'd3},
      {2'b00, 12'h021, 1'b1, 1'b1, 4'd8, 1'b1, 1'b0, 1'b1, 1'b0, 2'b00, 1'b1, 1'b0, 3'd3},
      {2'b10, 12'h031, 1'b1, 1'b1, 4'd8, 1'b1, 1'b0, 1'b1, 1'b0, 2'b00, 1'b1, 1'b0, 3'd3},
      {2'b00, 12'h231, 1'b1, 1'b1, 4'd8, 1'b1, 1'b0, 1'b1, 1'b0, 2'b00, 1'b1, 1'b0, 3'd3},
      {2'b00, 12'h0B1, 1'b1, 1'b0, 4'd2, 1'b0, 1'b1, 1'b0, 1'b0, 2'b00, 1'b1, 1'b0, 3'd3},
      {2'b01, 12'h000, 1'b1, 1'b0, 4'd2, 1'b0, 1'b1, 1'b0, 1'b1, 2'b00, 1'b1, 1'b1, 3'd3},
      {2'b01, 12'h043, 1'b1, 1'b0, 4'd2, 1'b0, 1'b1, 1'b0, 1'b0, 2'b11, 1'b1, 1'b1, 3'd3},
      {2'b01, 12'h004, 1'b1, 1'b1, 4'd2, 1'b0, 1'b1, 1'b0, 1'b0, 2'b11, 1'b1, 1'b1, 3'd3},
      {2'b01, 12'h100, 1'b1, 1'b1, 4'd2, 1'b0, 1'b1, 1'b0, 1'b0, 2'b11, 1'b1, 1'b1, 3'd3},
      {2'b00, 12'h032, 1'b0, 1'b1, 4'd2, 1'b0, 1'b1, 1'b0, 1'b0, 2'b11, 1'b1, 1'b1, 3'd3},
      {2'b01, 12'h000, 1'b0, 1'b1, 4'd2, 1'b0, 1'b1, 1'b0, 1'b0, 2'b11, 1'b1, 1'b1, 3'd3},
      {2'b01, 12'h040, 1'b1, 1'b0, 4'd2, 1'b0, 1'b1, 1'b0, 1'b1, 2'b10, 1'b1, 1'b1, 3'd3},
      {2'b00, 12'h032, 1'b1, 1'b0, 4'd4, 1'b0, 1'b0, 1'b0, 1'b1, 2'b10, 1'b1, 1'b1, 3'd3}
   };

   function automatic logic [15:0] observed();
      return {cfg_err, burst_beats, burst_interleave, test_mode, dll_reset,
              dll_enable, drive_code, mr_valid, emr_valid, cas_latency};
   endfunction

   task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", tag, got, exp);
      end
   endtask

   task automatic set_nop();
      cs_n = 1'b0; ras_n = 1'b1; cas_n = 1'b1; we_n = 1'b1; banks_idle = 1'b1;
   endtask

   task automatic set_load(input logic [1:0] b, input logic [11:0] a, input logic idle);
      cs_n = 1'b0; ras_n = 1'b0; cas_n = 1'b0; we_n = 1'b0;
      ba = b; addr = a; banks_idle = idle;
   endtask

   // one load edge followed by a return to NOP; returns just after the load edge
   task automatic apply(input logic [1:0] b, input logic [11:0] a, input logic idle);
      @(negedge clk); set_load(b, a, idle);
      @(negedge clk); set_nop();
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      check("R9 reset outputs", {16'b0, observed()}, 32'h0);
      check("R9 reset busy", {31'b0, busy}, 32'h0);
      rst_n = 1'b1; cke = 1'b1; set_nop();
      repeat (2) @(negedge clk);
      check("R10 unprogrammed after reset", {30'b0, mr_valid, emr_valid}, 32'h0);

      for (int i = 0; i < 15; i++) begin
         apply(VEC[i][30:29], VEC[i][28:17], VEC[i][16]);
         check($sformatf("R2 R3 R4 R5 R6 R7 R10 vector %0d", i),
               {16'b0, observed()}, {16'b0, VEC[i][15:0]});
         check($sformatf("R8 busy after vector %0d", i), {31'b0, busy}, {31'b0, ~VEC[i][15]});
      end
      // state now: beats 4, sequential, no errors
      @(negedge clk);
      check("R8 busy ends", {31'b0, busy}, 32'h0);

      // R1: deselected opcode ignored
      @(negedge clk); set_load(2'b00, 12'h13B, 1'b1); cs_n = 1'b1;
      @(negedge clk); set_nop();
      check("R1 cs_n high ignored", {16'b0, observed()}, {16'b0, VEC[14][15:0]});

      // R1: clock enable low at the previous edge
      @(negedge clk); cke = 1'b0;
      @(negedge clk); cke = 1'b1; set_load(2'b00, 12'h13B, 1'b1);
      @(negedge clk); set_nop();
      check("R1 cke just restored ignored", {16'b0, observed()}, {16'b0, VEC[14][15:0]});
      apply(2'b00, 12'h13B, 1'b1);
      check("R1 load after cke settled", {28'b0, burst_beats}, 32'd8);

      // R11: error held across other commands, cleared by a clean load
      @(negedge clk);
      apply(2'b00, 12'h034, 1'b1);
      check("R6 reserved burst code", {31'b0, cfg_err}, 32'h1);
      @(negedge clk); cs_n = 1'b0; ras_n = 1'b0; cas_n = 1'b1; we_n = 1'b1;
      @(negedge clk); set_nop();
      check("R11 other command keeps error", {31'b0, cfg_err}, 32'h1);
      apply(2'b00, 12'h032, 1'b1);
      check("R11 clean load clears error", {31'b0, cfg_err}, 32'h0);
      check("R3 beats back to 4", {28'b0, burst_beats}, 32'd4);

      // R8: load on the edge right after an accepted one
      @(negedge clk);
      @(negedge clk); set_load(2'b00, 12'h13B, 1'b1);
      @(negedge clk);
      check("R8 busy after accept", {31'b0, busy}, 32'h1);
      set_load(2'b00, 12'h032, 1'b1);
      @(negedge clk); set_nop();
      check("R8 second load refused", {27'b0, cfg_err, burst_beats}, {27'b0, 1'b1, 4'd8});
      check("R8 busy over", {31'b0, busy}, 32'h0);
      apply(2'b00, 12'h032, 1'b1);
      check("R8 load after gap accepted", {27'b0, cfg_err, burst_beats}, {27'b0, 1'b0, 4'd4});

      // R9: reset mid-run
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk);
      check("R9 reset mid-run", {15'b0, busy, observed()}, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule